// File: doc/BRIEF.md
# Cycle-Timed Memory Allocation Wrapper

This block puts a byte-wide backing RAM behind a command port that several requesters share. A requester can allocate a region, read or write single bytes through a pointer into that region, and free the region. The requester never sees physical addresses. Each allocation receives a virtual pointer from a growing virtual space. A small table maps every live allocation to its physical base and records its element size code, its element count, a reservation flag and the reservation owner. A read or write may target any byte inside an allocation, so pointer arithmetic works. The block finds the containing entry, takes the offset from its virtual base and adds that offset to the physical base.

Requesters are served one at a time in round-robin order. A control FSM holds each operation for a latency that is set separately for each opcode and then pulses a one-cycle done. Physical space comes from a bump pointer. The bump pointer is reclaimed only when the table becomes empty. Freeing an entry closes the gap in the table, so live entries always occupy slots 0 to n-1. Reservations give a requester exclusive access to one allocation until it releases it.

Top module: `memAllocWrapper`

## Requirements
- R1: Opcode 0 (allocate) with element count n>0 and size code s returns rspPtr equal to the next virtual pointer and sets rspErr=0. The allocation covers n<<s bytes (element width 2^s bytes). The first pointer after reset is VPTR_BASE (default 0x0100). Each further pointer is the previous pointer plus the previous allocation's byte length.
- R2: Opcode 1 (read) and opcode 2 (write) at a virtual address a inside an allocation [v, v+len) access physical byte pBase+(a-v). A read returns on rspData the byte last written there, and distinct allocations never share storage.
- R3: A read, write or free whose address lies in no live allocation returns rspErr=1 and leaves the table, the pointers and the RAM unchanged.
- R4: An allocate returns rspErr=1, rspPtr=0 and changes nothing in three cases: the table already holds TABLE_DEPTH entries, the count is zero, or the bump pointer plus the byte length exceeds PHYS_BYTES.
- R5: Opcode 3 (free) at any address inside a live allocation removes that entry. Later accesses to it return an error, the remaining entries keep translating correctly after compaction, and the freed virtual pointer is never handed out again.
- R6: When a free empties the table, the physical bump pointer returns to 0, so the whole PHYS_BYTES space can be allocated again.
- R7: A read or write with reqHold=1 marks the entry as reserved by that requester. An access by the owner with reqHold=0 releases it. While the entry is reserved, a read, write or free of it by any other requester returns rspErr=1 and changes nothing.
- R8: rspDone is high for exactly one cycle. It rises after LAT_ALLOC, LAT_READ, LAT_WRITE or LAT_FREE clock edges, counted from the edge at which the request was granted (defaults 3, 2, 1, 4).
- R9: Among requesters holding reqValid, the grant goes to the first one after the most recently granted index, searching upward with wrap-around. After reset the search starts at index 0, and rspId names the requester being answered.
- R10: After reset rspDone is 0 and the table is empty, so every access returns an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Per-requester request pending; held until that requester's done |
| reqOp | input | 2*NUM_REQ | Per-requester opcode: 0 allocate, 1 read, 2 write, 3 free |
| reqAddr | input | VADDR_W*NUM_REQ | Per-requester virtual address for read, write and free |
| reqCount | input | CNT_W*NUM_REQ | Per-requester element count for allocate |
| reqSize | input | 2*NUM_REQ | Per-requester element size code for allocate (2^code bytes) |
| reqHold | input | NUM_REQ | Per-requester reservation request for read and write |
| reqWData | input | DATA_W*NUM_REQ | Per-requester write byte |
| rspDone | output | 1 | One-cycle completion pulse |
| rspId | output | ID_W | Index of the requester being answered |
| rspErr | output | 1 | Operation refused; no state changed |
| rspPtr | output | VADDR_W | New virtual pointer for a successful allocate, else 0 |
| rspData | output | DATA_W | Byte read for a successful read, else 0 |

## Verification
Two functions can meet in the same cycle. Round-robin arbitration can receive competing requests in the same cycle as a reservation change. In particular, the owner's releasing access and another requester's access to the same reserved entry can both be pending, and the grant order decides whether the other requester is refused or served. The bench provokes this by raising several reqValid bits in the same cycle against a reserved entry. The outcome is judged by a behavioural model that picks the winner with its own rotation and applies the reservation state in that order, then compares rspDone, rspId, rspErr, rspPtr and rspData on every clock.

// File: rtl/memWrapPkg.sv
package memWrapPkg;

  typedef enum logic [1:0] {
    OP_ALLOC = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_FREE  = 2'd3
  } memOp_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;  // latch the granted request
    logic commit;   // apply the operation and register the response
  } ctrlStrobe_t;

endpackage

// File: rtl/mwArbiter.sv
module mwArbiter #(
  parameter int NUM_REQ = 4,
  parameter int ID_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqValid,
  input  logic               advance,
  output logic [ID_W-1:0]    grantId,
  output logic               anyValid
);

  logic [ID_W-1:0] lastId;
  logic            found;

  assign anyValid = |reqValid;

  always_comb begin
    grantId = '0;
    found   = 1'b0;
    for (int k = 1; k <= NUM_REQ; k++) begin
      if (!found && reqValid[(int'(lastId) + k) % NUM_REQ]) begin
        grantId = ID_W'((int'(lastId) + k) % NUM_REQ);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastId <= ID_W'(NUM_REQ - 1);
    else if (advance) lastId <= grantId;
  end

  // R9: the grant always points at a requester that is asking
  a_r9_grant_valid: assert property (@(posedge clk) disable iff (!rstN)
    anyValid |-> reqValid[grantId]);

endmodule

// File: rtl/mwControl.sv
module mwControl
  import memWrapPkg::*;
#(
  parameter int LAT_ALLOC = 3,
  parameter int LAT_READ  = 2,
  parameter int LAT_WRITE = 1,
  parameter int LAT_FREE  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyValid,
  input  memOp_e      grantOp,
  output ctrlStrobe_t strobe,
  output logic        rspDone
);

  localparam int LAT_M1 = (LAT_ALLOC > LAT_READ) ? LAT_ALLOC : LAT_READ;
  localparam int LAT_M2 = (LAT_WRITE > LAT_FREE) ? LAT_WRITE : LAT_FREE;
  localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int LAT_W = $clog2(LAT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} ctrlState_e;

  ctrlState_e      state;
  logic [LAT_W-1:0] waitCnt;
  logic [LAT_W-1:0] latInit;

  always_comb begin
    case (grantOp)
      OP_ALLOC: latInit = LAT_W'(LAT_ALLOC - 1);
      OP_READ:  latInit = LAT_W'(LAT_READ - 1);
      OP_WRITE: latInit = LAT_W'(LAT_WRITE - 1);
      default:  latInit = LAT_W'(LAT_FREE - 1);
    endcase
  end

  assign strobe.capture = (state == S_IDLE) && anyValid;
  assign strobe.commit  = (state == S_BUSY) && (waitCnt == '0);
  assign rspDone        = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (anyValid) begin
          state   <= S_BUSY;
          waitCnt <= latInit;
        end
        S_BUSY: if (waitCnt == '0) state <= S_DONE;
                else waitCnt <= waitCnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R8: a commit is always followed by done in the next cycle
  a_r8_commit_done: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> rspDone);

endmodule

// File: rtl/mwDatapath.sv
module mwDatapath
  import memWrapPkg::*;
#(
  parameter int NUM_REQ     = 4,
  parameter int TABLE_DEPTH = 4,
  parameter int PHYS_BYTES  = 64,
  parameter int VADDR_W     = 16,
  parameter int CNT_W       = 6,
  parameter int DATA_W      = 8,
  parameter logic [VADDR_W-1:0] VPTR_BASE = 16'h0100,
  parameter int ID_W        = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  memOp_e             selOp,
  input  logic [ID_W-1:0]    selId,
  input  logic [VADDR_W-1:0] selAddr,
  input  logic [CNT_W-1:0]   selCount,
  input  logic [1:0]         selSize,
  input  logic               selHold,
  input  logic [DATA_W-1:0]  selWData,
  output logic [ID_W-1:0]    rspId,
  output logic               rspErr,
  output logic [VADDR_W-1:0] rspPtr,
  output logic [DATA_W-1:0]  rspData
);

  localparam int IDX_W   = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1;
  localparam int NUM_W   = $clog2(TABLE_DEPTH + 1);
  localparam int PIDX_W  = $clog2(PHYS_BYTES);
  localparam int PADDR_W = PIDX_W + 1;
  localparam int LEN_W   = CNT_W + 3;
  localparam int EXT_W   = VADDR_W + 1;
  localparam int SUM_W   = ((LEN_W > PADDR_W) ? LEN_W : PADDR_W) + 1;

  typedef struct packed {
    logic [VADDR_W-1:0] vBase;
    logic [PADDR_W-1:0] pBase;
    logic [CNT_W-1:0]   count;
    logic [1:0]         sizeCode;
    logic               resv;
    logic [ID_W-1:0]    owner;
  } tblEntry_t;

  // latched request
  memOp_e             lOp;
  logic [ID_W-1:0]    lId;
  logic [VADDR_W-1:0] lAddr;
  logic [CNT_W-1:0]   lCount;
  logic [1:0]         lSize;
  logic               lHold;
  logic [DATA_W-1:0]  lWData;

  // table and allocator state
  tblEntry_t          tbl [TABLE_DEPTH];
  logic [NUM_W-1:0]   numUsed;
  logic [VADDR_W-1:0] nextVptr;
  logic [PADDR_W-1:0] bumpPtr;
  logic [DATA_W-1:0]  ram [PHYS_BYTES];

  logic [LEN_W-1:0]       entLen [TABLE_DEPTH];
  logic [TABLE_DEPTH-1:0] hitVec;
  logic [IDX_W-1:0]       hitIdx;
  logic                   anyHit;
  tblEntry_t              hitEnt;
  logic [VADDR_W-1:0]     offset;
  logic [PADDR_W-1:0]     physAddr;
  logic [PIDX_W-1:0]      physIdx;
  logic                   foreign;
  logic [LEN_W-1:0]       newLen;
  logic [SUM_W-1:0]       bumpEnd;
  logic                   allocOk;
  logic                   opOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lOp    <= OP_ALLOC;
      lId    <= '0;
      lAddr  <= '0;
      lCount <= '0;
      lSize  <= '0;
      lHold  <= 1'b0;
      lWData <= '0;
    end else if (strobe.capture) begin
      lOp    <= selOp;
      lId    <= selId;
      lAddr  <= selAddr;
      lCount <= selCount;
      lSize  <= selSize;
      lHold  <= selHold;
      lWData <= selWData;
    end
  end

  // parallel range match over every live entry
  for (genvar i = 0; i < TABLE_DEPTH; i++) begin : g_hit
    assign entLen[i] = LEN_W'(tbl[i].count) << tbl[i].sizeCode;
    assign hitVec[i] = (NUM_W'(i) < numUsed)
                     && (lAddr >= tbl[i].vBase)
                     && (EXT_W'(lAddr) < EXT_W'(tbl[i].vBase) + EXT_W'(entLen[i]));
  end

  always_comb begin
    hitIdx = '0;
    anyHit = 1'b0;
    for (int i = TABLE_DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  assign hitEnt   = tbl[hitIdx];
  assign offset   = lAddr - hitEnt.vBase;
  assign physAddr = hitEnt.pBase + PADDR_W'(offset);
  assign physIdx  = physAddr[PIDX_W-1:0];
  assign foreign  = hitEnt.resv && (hitEnt.owner != lId);

  assign newLen  = LEN_W'(lCount) << lSize;
  assign bumpEnd = SUM_W'(bumpPtr) + SUM_W'(newLen);
  assign allocOk = (numUsed < NUM_W'(TABLE_DEPTH)) && (lCount != '0)
                 && (bumpEnd <= SUM_W'(PHYS_BYTES));
  assign opOk    = (lOp == OP_ALLOC) ? allocOk : (anyHit && !foreign);

  // table, pointers and compaction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      numUsed  <= '0;
      nextVptr <= VPTR_BASE;
      bumpPtr  <= '0;
      for (int i = 0; i < TABLE_DEPTH; i++) tbl[i] <= '0;
    end else if (strobe.commit && opOk) begin
      case (lOp)
        OP_ALLOC: begin
          tbl[numUsed[IDX_W-1:0]] <= '{vBase: nextVptr, pBase: bumpPtr,
                                       count: lCount, sizeCode: lSize,
                                       resv: 1'b0, owner: '0};
          numUsed  <= numUsed + 1'b1;
          nextVptr <= nextVptr + VADDR_W'(newLen);
          bumpPtr  <= PADDR_W'(bumpEnd);
        end
        OP_READ, OP_WRITE: begin
          tbl[hitIdx].resv  <= lHold;
          tbl[hitIdx].owner <= lId;
        end
        default: begin
          for (int i = 0; i < TABLE_DEPTH - 1; i++) begin
            if (IDX_W'(i) >= hitIdx) tbl[i] <= tbl[i + 1];
          end
          numUsed <= numUsed - 1'b1;
          if (numUsed == NUM_W'(1)) bumpPtr <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit && opOk && (lOp == OP_WRITE)) ram[physIdx] <= lWData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspId   <= '0;
      rspErr  <= 1'b0;
      rspPtr  <= '0;
      rspData <= '0;
    end else if (strobe.commit) begin
      rspId   <= lId;
      rspErr  <= !opOk;
      rspPtr  <= (opOk && lOp == OP_ALLOC) ? nextVptr : '0;
      rspData <= (opOk && lOp == OP_READ) ? ram[physIdx] : '0;
    end
  end

  // R4: an allocate into a full table is refused and the table stays full
  a_r4_full_alloc_err: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && lOp == OP_ALLOC && numUsed == NUM_W'(TABLE_DEPTH))
    |=> (rspErr && numUsed == NUM_W'(TABLE_DEPTH)));

  // R3: a miss changes neither the table size nor the virtual pointer
  a_r3_miss_nochange: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && lOp != OP_ALLOC && !anyHit)
    |=> (rspErr && $stable(numUsed) && $stable(nextVptr)));

  // R7: an entry reserved by someone else refuses the access
  a_r7_foreign_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && lOp != OP_ALLOC && anyHit && foreign)
    |=> (rspErr && $stable(numUsed)));

  // R6: an empty table always has its physical space fully reclaimed
  a_r6_empty_bump: assert property (@(posedge clk) disable iff (!rstN)
    (numUsed == '0) |-> (bumpPtr == '0));

  // R2: live entries never translate beyond the physical space
  a_r2_phys_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && lOp != OP_ALLOC && anyHit) |-> (physAddr < PADDR_W'(PHYS_BYTES)));

endmodule

// File: rtl/memAllocWrapper.sv
module memAllocWrapper
  import memWrapPkg::*;
#(
  parameter int NUM_REQ     = 4,
  parameter int TABLE_DEPTH = 4,
  parameter int PHYS_BYTES  = 64,
  parameter int VADDR_W     = 16,
  parameter int CNT_W       = 6,
  parameter int DATA_W      = 8,
  parameter logic [VADDR_W-1:0] VPTR_BASE = 16'h0100,
  parameter int LAT_ALLOC   = 3,
  parameter int LAT_READ    = 2,
  parameter int LAT_WRITE   = 1,
  parameter int LAT_FREE    = 4,
  localparam int ID_W       = $clog2(NUM_REQ)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REQ-1:0]         reqValid,
  input  logic [2*NUM_REQ-1:0]       reqOp,
  input  logic [VADDR_W*NUM_REQ-1:0] reqAddr,
  input  logic [CNT_W*NUM_REQ-1:0]   reqCount,
  input  logic [2*NUM_REQ-1:0]       reqSize,
  input  logic [NUM_REQ-1:0]         reqHold,
  input  logic [DATA_W*NUM_REQ-1:0]  reqWData,
  output logic                       rspDone,
  output logic [ID_W-1:0]            rspId,
  output logic                       rspErr,
  output logic [VADDR_W-1:0]         rspPtr,
  output logic [DATA_W-1:0]          rspData
);

  logic [ID_W-1:0] grantId;
  logic            anyValid;
  ctrlStrobe_t     strobe;
  memOp_e          grantOp;

  assign grantOp = memOp_e'(reqOp[2*grantId +: 2]);

  mwArbiter #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_arb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .advance(strobe.capture),
    .grantId(grantId), .anyValid(anyValid)
  );

  mwControl #(
    .LAT_ALLOC(LAT_ALLOC), .LAT_READ(LAT_READ),
    .LAT_WRITE(LAT_WRITE), .LAT_FREE(LAT_FREE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .anyValid(anyValid), .grantOp(grantOp),
    .strobe(strobe), .rspDone(rspDone)
  );

  mwDatapath #(
    .NUM_REQ(NUM_REQ), .TABLE_DEPTH(TABLE_DEPTH), .PHYS_BYTES(PHYS_BYTES),
    .VADDR_W(VADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .VPTR_BASE(VPTR_BASE), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .selOp(grantOp),
    .selId(grantId),
    .selAddr(reqAddr[VADDR_W*grantId +: VADDR_W]),
    .selCount(reqCount[CNT_W*grantId +: CNT_W]),
    .selSize(reqSize[2*grantId +: 2]),
    .selHold(reqHold[grantId]),
    .selWData(reqWData[DATA_W*grantId +: DATA_W]),
    .rspId(rspId), .rspErr(rspErr), .rspPtr(rspPtr), .rspData(rspData)
  );

endmodule

// File: tb/test_memAllocWrapper.sv
`timescale 1ns/1ps
module test_memAllocWrapper;

  localparam int NR = 4;
  localparam int VW = 16;
  localparam int CW = 6;
  localparam int DW = 8;
  localparam int TD = 4;
  localparam int PB = 64;
  localparam int LATS [4] = '{3, 2, 1, 4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [NR-1:0]    drvValid = '0;
  logic [1:0]       drvOp   [NR];
  logic [VW-1:0]    drvAddr [NR];
  logic [CW-1:0]    drvCnt  [NR];
  logic [1:0]       drvSz   [NR];
  logic [NR-1:0]    drvHold = '0;
  logic [DW-1:0]    drvWd   [NR];

  logic [2*NR-1:0]  reqOp;
  logic [VW*NR-1:0] reqAddr;
  logic [CW*NR-1:0] reqCount;
  logic [2*NR-1:0]  reqSize;
  logic [DW*NR-1:0] reqWData;

  logic          rspDone;
  logic [1:0]    rspId;
  logic          rspErr;
  logic [VW-1:0] rspPtr;
  logic [DW-1:0] rspData;

  always_comb begin
    for (int k = 0; k < NR; k++) begin
      reqOp[2*k +: 2]     = drvOp[k];
      reqAddr[VW*k +: VW] = drvAddr[k];
      reqCount[CW*k +: CW] = drvCnt[k];
      reqSize[2*k +: 2]   = drvSz[k];
      reqWData[DW*k +: DW] = drvWd[k];
    end
  end

  memAllocWrapper i_memAllocWrapper (
    .clk(clk), .rstN(rstN), .reqValid(drvValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqCount(reqCount), .reqSize(reqSize),
    .reqHold(drvHold), .reqWData(reqWData),
    .rspDone(rspDone), .rspId(rspId), .rspErr(rspErr),
    .rspPtr(rspPtr), .rspData(rspData)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mSt, mLeft, mLast;
  int qV[$], qP[$], qL[$], qO[$];
  bit qR[$];
  int nextV, bump;
  int mem [PB];
  int eId, eErr, ePtr, eData;
  string eTag;

  function automatic int findEntry(input int a);
    for (int i = 0; i < qV.size(); i++)
      if (a >= qV[i] && a < qV[i] + qL[i]) return i;
    return -1;
  endfunction

  task automatic modelExec(input int g);
    int op, a, len, e;
    op = drvOp[g];
    a = drvAddr[g];
    eId = g; eErr = 0; ePtr = 0; eData = 0;
    if (op == 0) begin
      len = int'(drvCnt[g]) << drvSz[g];
      if (qV.size() == TD || drvCnt[g] == 0 || bump + len > PB) begin
        eErr = 1; eTag = "R4";
      end else begin
        qV.push_back(nextV); qP.push_back(bump); qL.push_back(len);
        qR.push_back(1'b0); qO.push_back(0);
        ePtr = nextV; nextV += len; bump += len;
        eTag = (qV.size() == 1 && bump == len) ? "R6" : "R1";
      end
    end else begin
      e = findEntry(a);
      if (e < 0) begin
        eErr = 1; eTag = "R3";
      end else if (qR[e] && qO[e] != g) begin
        eErr = 1; eTag = "R7";
      end else if (op == 3) begin
        qV.delete(e); qP.delete(e); qL.delete(e); qR.delete(e); qO.delete(e);
        if (qV.size() == 0) bump = 0;
        eTag = "R5";
      end else begin
        if (op == 1) eData = mem[qP[e] + a - qV[e]];
        else mem[qP[e] + a - qV[e]] = int'(drvWd[g]);
        qR[e] = drvHold[g]; qO[e] = g;
        eTag = drvHold[g] ? "R7" : "R2";
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mLast = NR - 1; nextV = 'h100; bump = 0;
      qV.delete(); qP.delete(); qL.delete(); qR.delete(); qO.delete();
    end else begin
      case (mSt)
        0: if (drvValid != 0) begin
          for (int k = 1; k <= NR; k++) begin
            if (mSt == 0 && drvValid[(mLast + k) % NR]) begin
              mLast = (mLast + k) % NR;
              modelExec(mLast);
              mLeft = LATS[drvOp[mLast]];
              mSt = 1;
            end
          end
        end
        1: begin mLeft--; if (mLeft == 0) mSt = 2; end
        default: mSt = 0;
      endcase
    end
  end

  // compare every cycle, then retire the answered requester
  always @(negedge clk) begin
    if (rstN) begin
      chk(rspDone == (mSt == 2), "R8", "done timing", rspDone, mSt == 2);
      if (mSt == 2) begin
        chk(rspId == eId, "R9", "served id", rspId, eId);
        chk(rspErr == eErr, eTag, "err", rspErr, eErr);
        chk(rspPtr == ePtr, eTag, "pointer", rspPtr, ePtr);
        chk(rspData == eData, eTag, "data", rspData, eData);
      end
      if (rspDone) drvValid[rspId] = 1'b0;
    end
  end

  task automatic post(input int k, input int op, input int a, input int c,
                      input int s, input bit h, input int wd);
    drvOp[k] = 2'(op); drvAddr[k] = VW'(a); drvCnt[k] = CW'(c);
    drvSz[k] = 2'(s); drvHold[k] = h; drvWd[k] = DW'(wd);
    drvValid[k] = 1'b1;
  endtask

  task automatic waitAll();
    while (drvValid != 0) @(negedge clk);
  endtask

  task automatic one(input int k, input int op, input int a, input int c,
                     input int s, input bit h, input int wd);
    @(negedge clk);
    post(k, op, a, c, s, h, wd);
    waitAll();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) begin
      drvOp[k] = 0; drvAddr[k] = 0; drvCnt[k] = 0; drvSz[k] = 0; drvWd[k] = 0;
    end
    repeat (4) @(negedge clk);
    chk(rspDone == 1'b0, "R10", "done in reset", rspDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rspDone == 1'b0, "R10", "done after reset", rspDone, 0);
    one(0, 1, 'h100, 0, 0, 0, 0);                // R10: empty table refuses a read
    // R1 allocations
    one(0, 0, 0, 4, 0, 0, 0);                    // 0x100, 4 bytes
    one(1, 0, 0, 2, 2, 0, 0);                    // 0x104, 8 bytes
    one(2, 0, 0, 3, 1, 0, 0);                    // 0x10C, 6 bytes
    // R2 write and read back, with offsets
    one(0, 2, 'h103, 0, 0, 0, 'hAA);
    one(1, 2, 'h109, 0, 0, 0, 'h55);
    one(2, 2, 'h10C, 0, 0, 0, 'h11);
    one(3, 1, 'h103, 0, 0, 0, 0);
    one(3, 1, 'h109, 0, 0, 0, 0);
    one(3, 1, 'h10C, 0, 0, 0, 0);
    // R3 misses
    one(0, 1, 'h200, 0, 0, 0, 0);
    one(1, 2, 'h0FF, 0, 0, 0, 'h33);
    one(2, 3, 'h112, 0, 0, 0, 0);
    // R4 refused allocations
    one(0, 0, 0, 0, 1, 0, 0);                    // zero count
    one(0, 0, 0, 63, 0, 0, 0);                   // 18+63 > 64
    one(3, 0, 0, 4, 0, 0, 0);                    // 0x112 fits
    one(0, 0, 0, 1, 0, 0, 0);                    // table full
    // R7 reservation
    one(1, 1, 'h104, 0, 0, 1, 0);
    one(2, 2, 'h104, 0, 0, 0, 'h77);
    one(2, 3, 'h105, 0, 0, 0, 0);
    one(2, 1, 'h109, 0, 0, 0, 0);
    one(1, 2, 'h106, 0, 0, 1, 'h66);
    one(1, 1, 'h109, 0, 0, 0, 0);                // release
    one(2, 2, 'h104, 0, 0, 0, 'h77);
    // R9 all requesters at once, racing a reservation
    one(3, 2, 'h10D, 0, 0, 1, 'h22);             // requester 3 reserves 0x10C
    @(negedge clk);
    post(0, 1, 'h103, 0, 0, 0, 0);
    post(1, 1, 'h10D, 0, 0, 0, 0);
    post(2, 2, 'h104, 0, 0, 1, 'h44);
    post(3, 1, 'h10D, 0, 0, 0, 0);
    waitAll();
    @(negedge clk);
    post(0, 1, 'h104, 0, 0, 0, 0);
    post(2, 1, 'h104, 0, 0, 0, 0);
    post(1, 2, 'h10C, 0, 0, 0, 'h99);
    waitAll();
    // R5 free the middle entry, neighbours still translate
    one(1, 3, 'h106, 0, 0, 0, 0);
    one(0, 1, 'h104, 0, 0, 0, 0);
    one(0, 1, 'h10D, 0, 0, 0, 0);
    one(0, 1, 'h103, 0, 0, 0, 0);
    one(3, 2, 'h112, 0, 0, 0, 'h5A);
    one(2, 1, 'h112, 0, 0, 0, 0);
    // R6 empty the table and reuse the whole space
    one(0, 3, 'h100, 0, 0, 0, 0);
    one(0, 3, 'h10C, 0, 0, 0, 0);
    one(0, 3, 'h113, 0, 0, 0, 0);
    one(1, 0, 0, 16, 2, 0, 0);                   // 64 bytes at the next pointer
    one(1, 2, 'h153, 0, 0, 0, 'hC3);
    one(2, 1, 'h153, 0, 0, 0, 0);
    one(3, 0, 0, 1, 0, 0, 0);                    // no space left
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule